// File: doc/BRIEF.md
# Stereo Audio DAC Sample Interface

This block sits between a system bus and the modulator of a stereo bitstream DAC. Software, or a DMA engine, writes one 32-bit word that carries a left and a right 16-bit sample into a holding register. The DAC-clock side consumes one pair every 256 DAC clock cycles, so a 12.288 MHz DAC clock yields a 48 kHz sample rate. At each consumption tick the newest pair is handed to the modulator together with a one-cycle valid strobe.

The bus side keeps a small register file: an enable control, the sample word, a two-bit event status that clears on read or on a write of ones to an acknowledge register, and an interrupt mask that is built through separate set and clear registers. A level interrupt is raised while any pending status bit is unmasked. A DMA request stays high while the holding register can accept a word. When a tick finds no new pair, the modulator keeps the previous pair and an underrun event is reported. The written word and the events cross between the bus clock and the DAC clock through toggle handshakes.

Top module: `sdac_stereo_if`

## Requirements
- R1: While enabled, `pcm_valid` pulses for one DAC clock cycle exactly once every 256 DAC clock cycles.
- R2: A word written at byte offset 0x04 delivers bits [15:0] on `pcm_left` and bits [31:16] on `pcm_right`, at the first `pcm_valid` pulse after the write.
- R3: While bit 0 of the control register (offset 0x00) is 0, `pcm_valid` and `dma_req` stay low and writes to offset 0x04 are dropped.
- R4: Status bit 0 (ready, status register at offset 0x08) is set when the holding register becomes free: on enable and after each transfer of a written pair.
- R5: Status bit 1 (underrun) is set when a tick finds no new pair since the previous transfer.
- R6: A read of offset 0x08 returns the status and clears it. Writing ones to offset 0x0C clears the matching status bits.
- R7: Writing ones to offset 0x10 sets mask bits. Writing ones to offset 0x14 clears mask bits. The mask reads back at offset 0x18, with bit positions matching the status bits.
- R8: `irq` is high exactly while some status bit is set and its mask bit is set.
- R9: `dma_req` is high while the block is enabled and the holding register is free.
- R10: On an underrun tick, `pcm_left` and `pcm_right` repeat the previous pair.
- R11: An accepted write to offset 0x04 clears status bit 0 and drops `dma_req` in the next bus cycle, until the pair has been transferred.
- R12: A write to offset 0x04 while the holding register is still occupied is discarded. The earlier pair is the one delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe, one bus cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the read |
| irq | output | 1 | Level interrupt |
| dma_req | output | 1 | Request for a new sample word |
| dac_clk | input | 1 | DAC clock, 256 times the sample rate |
| dac_rst_n | input | 1 | DAC-domain synchronous reset, active low |
| pcm_left | output | 16 | Left sample to the modulator |
| pcm_right | output | 16 | Right sample to the modulator |
| pcm_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The checks assume that bus accesses are single-cycle strobes and that each access touches one register. They also assume the DAC-side period is at least two cycles, so two ticks never fall on adjacent DAC cycles. The stimulus issues every access as one strobe between falling bus clock edges. Each sample write is placed just after a `pcm_valid` pulse, so the toggle can cross well before the next tick. Only the dropped-write case puts a second write into the busy window on purpose.

// File: rtl/sdac_pkg.sv
// Package: shared constants of the stereo DAC sample interface.
// Assumes a 32-bit bus and byte offsets on a 5-bit address.
package sdac_pkg;
    localparam int unsigned BUS_W   = 32;
    localparam int unsigned ADDR_W  = 5;
    localparam int unsigned NSTAT   = 2;

    // status bit positions (mask uses the same positions)
    localparam int unsigned ST_READY = 0;
    localparam int unsigned ST_URUN  = 1;

    // register byte offsets
    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DATA = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_ACK  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_MSET = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_MCLR = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_MASK = 5'h18;

    typedef logic [NSTAT-1:0] stat_t;
endpackage

// File: rtl/sdac_sync.sv
// Multi-stage synchronizer for level or toggle signals entering a clock domain.
// Assumes each bit is independent (toggles or slow levels), so no bus coherence is needed.
module sdac_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // first stage samples the foreign signal
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // later stages settle metastability
        always_ff @(posedge clk) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= stg[g-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_bus_regs.sv
// Bus-side register file: control, holding register, event status, mask, irq, DMA request.
// Assumes single-cycle access strobes; ack_tgl_s and urun_tgl_s are already synchronized.
// The holding register changes only while free, so the DAC side may sample it directly.
module sdac_bus_regs
    import sdac_pkg::*;
#(
    parameter int unsigned PAIR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              ack_tgl_s,
    input  logic              urun_tgl_s,
    output logic              enable,
    output logic              wr_tgl,
    output logic [PAIR_W-1:0] hold_pair,
    output logic              irq,
    output logic              dma_req
);
    logic  en_q, wr_tgl_q, free_q, urun_seen_q;
    logic  [PAIR_W-1:0] hold_q;
    stat_t stat_q, mask_q;
    logic  wr_hit, rd_hit, slot_free, data_take, ready_rise, urun_evt;
    stat_t st_set, st_clr;

    assign wr_hit     = bus_sel &&  bus_wr;
    assign rd_hit     = bus_sel && !bus_wr;
    assign slot_free  = en_q && (wr_tgl_q == ack_tgl_s);
    assign data_take  = wr_hit && (bus_addr == OFS_DATA) && slot_free;
    assign ready_rise = slot_free && !free_q;
    assign urun_evt   = urun_tgl_s ^ urun_seen_q;

    // event set and clear vectors for the status register
    always_comb begin
        st_set           = '0;
        st_set[ST_READY] = ready_rise;
        st_set[ST_URUN]  = urun_evt;
        st_clr           = '0;
        if (rd_hit && bus_addr == OFS_STAT) st_clr = '1;
        if (wr_hit && bus_addr == OFS_ACK)  st_clr = st_clr | bus_wdata[NSTAT-1:0];
        if (data_take)                      st_clr[ST_READY] = 1'b1;
    end

    // control enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)                                en_q <= 1'b0;
        else if (wr_hit && bus_addr == OFS_CTRL)   en_q <= bus_wdata[0];
    end

    // holding register and the request toggle toward the DAC side
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= '0;
            wr_tgl_q <= 1'b0;
        end else if (data_take) begin
            hold_q   <= bus_wdata[PAIR_W-1:0];
            wr_tgl_q <= ~wr_tgl_q;
        end
    end

    // edge trackers for ready and underrun events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_q      <= 1'b0;
            urun_seen_q <= 1'b0;
        end else begin
            free_q      <= slot_free;
            urun_seen_q <= urun_tgl_s;
        end
    end

    // status register: set wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~st_clr) | st_set;
    end

    // interrupt mask through set and clear registers
    always_ff @(posedge clk) begin
        if (!rst_n)                               mask_q <= '0;
        else if (wr_hit && bus_addr == OFS_MSET)  mask_q <= mask_q |  bus_wdata[NSTAT-1:0];
        else if (wr_hit && bus_addr == OFS_MCLR)  mask_q <= mask_q & ~bus_wdata[NSTAT-1:0];
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else if (rd_hit) begin
            case (bus_addr)
                OFS_CTRL: bus_rdata <= {{(BUS_W-1){1'b0}}, en_q};
                OFS_DATA: bus_rdata <= {{(BUS_W-PAIR_W){1'b0}}, hold_q};
                OFS_STAT: bus_rdata <= {{(BUS_W-NSTAT){1'b0}}, stat_q};
                OFS_MASK: bus_rdata <= {{(BUS_W-NSTAT){1'b0}}, mask_q};
                default:  bus_rdata <= '0;
            endcase
        end
    end

    assign enable    = en_q;
    assign wr_tgl    = wr_tgl_q;
    assign hold_pair = hold_q;
    assign irq       = |(stat_q & mask_q);
    assign dma_req   = slot_free;

    // R11: an accepted sample write withdraws the request next cycle
    p_write_drops_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        data_take |=> !dma_req);

    // R12: the holding register never moves while it is occupied
    p_hold_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_free |=> $stable(hold_q));

    // R6: a status read without a new event leaves the status empty
    p_rdclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && bus_addr == OFS_STAT && !urun_evt && !ready_rise) |=> (stat_q == '0));

    // R7: a mask-set write turns on the written bits
    p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && bus_addr == OFS_MSET) |=> ((mask_q & $past(bus_wdata[NSTAT-1:0])) == $past(bus_wdata[NSTAT-1:0])));
endmodule

// File: rtl/sdac_dac_core.sv
// DAC-clock side: sample period counter, pair transfer, underrun detection.
// Assumes hold_pair is stable whenever wr_tgl_s differs from the last acknowledged toggle.
module sdac_dac_core #(
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned PERIOD   = 256
) (
    input  logic                  dac_clk,
    input  logic                  dac_rst_n,
    input  logic                  en_s,
    input  logic                  wr_tgl_s,
    input  logic [2*SAMPLE_W-1:0] hold_pair,
    output logic                  ack_tgl,
    output logic                  urun_tgl,
    output logic [SAMPLE_W-1:0]   pcm_left,
    output logic [SAMPLE_W-1:0]   pcm_right,
    output logic                  pcm_valid
);
    localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0]    cnt_q;
    logic                ack_q, urun_q, valid_q, tick, fresh;
    logic [SAMPLE_W-1:0] left_q, right_q;

    assign tick  = en_s && (cnt_q == LAST);
    assign fresh = wr_tgl_s ^ ack_q;

    // sample period counter, held at zero while disabled
    always_ff @(posedge dac_clk) begin
        if (!dac_rst_n || !en_s) cnt_q <= '0;
        else if (tick)           cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    // transfer a fresh pair or flag an underrun and keep the old pair
    always_ff @(posedge dac_clk) begin
        if (!dac_rst_n) begin
            left_q  <= '0;
            right_q <= '0;
            ack_q   <= 1'b0;
            urun_q  <= 1'b0;
        end else if (tick) begin
            if (fresh) begin
                left_q  <= hold_pair[SAMPLE_W-1:0];
                right_q <= hold_pair[2*SAMPLE_W-1:SAMPLE_W];
                ack_q   <= wr_tgl_s;
            end else begin
                urun_q  <= ~urun_q;
            end
        end
    end

    // one-cycle strobe marking the presented pair
    always_ff @(posedge dac_clk) begin
        if (!dac_rst_n) valid_q <= 1'b0;
        else            valid_q <= tick;
    end

    assign ack_tgl   = ack_q;
    assign urun_tgl  = urun_q;
    assign pcm_left  = left_q;
    assign pcm_right = right_q;
    assign pcm_valid = valid_q;

    // R1: handoff strobes never land on adjacent cycles
    p_tick_spacing_r1: assert property (@(posedge dac_clk) disable iff (!dac_rst_n)
        pcm_valid |=> !pcm_valid);

    // R10: an underrun tick keeps the previous pair on the outputs
    p_repeat_r10: assert property (@(posedge dac_clk) disable iff (!dac_rst_n)
        (tick && !fresh) |=> ($stable(pcm_left) && $stable(pcm_right)));

    // R5: an underrun event flips the toggle sent to the bus side
    p_urun_flag_r5: assert property (@(posedge dac_clk) disable iff (!dac_rst_n)
        (tick && !fresh) |=> (urun_q != $past(urun_q)));
endmodule

// File: rtl/sdac_stereo_if.sv
// Top: stereo DAC sample interface joining the bus register file and the DAC-clock core.
// Assumes clk and dac_clk are unrelated; every crossing is a level or a toggle.
module sdac_stereo_if
    import sdac_pkg::*;
#(
    parameter int unsigned SAMPLE_W    = 16,
    parameter int unsigned PERIOD      = 256,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [4:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                irq,
    output logic                dma_req,
    input  logic                dac_clk,
    input  logic                dac_rst_n,
    output logic [SAMPLE_W-1:0] pcm_left,
    output logic [SAMPLE_W-1:0] pcm_right,
    output logic                pcm_valid
);
    localparam int unsigned PAIR_W = 2 * SAMPLE_W;

    logic              enable, wr_tgl, ack_tgl, urun_tgl;
    logic [PAIR_W-1:0] hold_pair;
    logic [1:0]        to_dac_s, to_bus_s;

    sdac_bus_regs #(.PAIR_W(PAIR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ack_tgl_s  (to_bus_s[0]),
        .urun_tgl_s (to_bus_s[1]),
        .enable     (enable),
        .wr_tgl     (wr_tgl),
        .hold_pair  (hold_pair),
        .irq        (irq),
        .dma_req    (dma_req)
    );

    sdac_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync_to_dac (
        .clk   (dac_clk),
        .rst_n (dac_rst_n),
        .d     ({wr_tgl, enable}),
        .q     (to_dac_s)
    );

    sdac_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync_to_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({urun_tgl, ack_tgl}),
        .q     (to_bus_s)
    );

    sdac_dac_core #(.SAMPLE_W(SAMPLE_W), .PERIOD(PERIOD)) u_core (
        .dac_clk   (dac_clk),
        .dac_rst_n (dac_rst_n),
        .en_s      (to_dac_s[0]),
        .wr_tgl_s  (to_dac_s[1]),
        .hold_pair (hold_pair),
        .ack_tgl   (ack_tgl),
        .urun_tgl  (urun_tgl),
        .pcm_left  (pcm_left),
        .pcm_right (pcm_right),
        .pcm_valid (pcm_valid)
    );
endmodule

// File: tb/tb_sdac_stereo_if.sv
// Directed bench for the stereo DAC sample interface; one task per scenario.
module tb_sdac_stereo_if;
    localparam int CLK_PERIOD = 10;
    localparam int DAC_PERIOD = 16;

    logic        clk = 1'b0, dac_clk = 1'b0;
    logic        rst_n = 1'b0, dac_rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, dma_req, pcm_valid;
    logic [15:0] pcm_left, pcm_right;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(DAC_PERIOD/2) dac_clk = ~dac_clk;

    sdac_stereo_if dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .dma_req(dma_req), .dac_clk(dac_clk), .dac_rst_n(dac_rst_n),
        .pcm_left(pcm_left), .pcm_right(pcm_right), .pcm_valid(pcm_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic bus_idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // waits for a pcm_valid pulse; returns 0 if none within the limit
    task automatic wait_strobe(input int limit, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(posedge dac_clk); #1;
            if (pcm_valid) begin seen = 1'b1; break; end
        end
    endtask

    task automatic t_reset();
        logic [31:0] r;
        chk("R3 reset dma_req", {31'b0, dma_req}, 32'h0);
        chk("R8 reset irq", {31'b0, irq}, 32'h0);
        chk("R2 reset pcm", {pcm_right, pcm_left}, 32'h0);
        bus_read(5'h00, r); chk("R3 reset ctrl", r, 32'h0);
        bus_read(5'h18, r); chk("R7 reset mask", r, 32'h0);
        bus_read(5'h08, r); chk("R6 reset status", r, 32'h0);
    endtask

    task automatic t_disabled();
        bit seen;
        logic [31:0] r;
        bus_write(5'h04, 32'hDEAD_BEEF);
        wait_strobe(600, seen);
        chk("R3 no strobe while off", {31'b0, seen}, 32'h0);
        chk("R3 dma_req low while off", {31'b0, dma_req}, 32'h0);
        bus_read(5'h04, r); chk("R3 write dropped while off", r, 32'h0);
        bus_read(5'h08, r); chk("R3 no status while off", r, 32'h0);
    endtask

    task automatic t_enable_ready();
        logic [31:0] r;
        bus_write(5'h00, 32'h1);
        bus_idle(2);
        chk("R9 dma_req on enable", {31'b0, dma_req}, 32'h1);
        bus_read(5'h08, r); chk("R4 ready on enable", r, 32'h1);
        bus_read(5'h08, r); chk("R6 read clears status", r, 32'h0);
    endtask

    task automatic t_transfer();
        bit seen;
        logic [31:0] r;
        bus_write(5'h04, 32'hBBBB_AAAA);
        chk("R11 dma_req drops after write", {31'b0, dma_req}, 32'h0);
        bus_read(5'h08, r); chk("R11 ready clear after write", r, 32'h0);
        wait_strobe(600, seen);
        chk("R1 strobe after enable", {31'b0, seen}, 32'h1);
        chk("R2 left lane", {16'h0, pcm_left}, 32'h0000_AAAA);
        chk("R2 right lane", {16'h0, pcm_right}, 32'h0000_BBBB);
        bus_idle(8);
        chk("R9 dma_req back after transfer", {31'b0, dma_req}, 32'h1);
        bus_read(5'h08, r); chk("R4 ready after transfer", r, 32'h1);
    endtask

    task automatic t_period();
        bit seen;
        int n = 0;
        wait_strobe(600, seen);
        for (int i = 0; i < 1000; i++) begin
            @(posedge dac_clk); #1;
            n++;
            if (pcm_valid) break;
        end
        chk("R1 period in dac cycles", n, 256);
    endtask

    task automatic t_underrun();
        bit seen;
        logic [31:0] r;
        wait_strobe(600, seen);
        chk("R10 repeat left", {16'h0, pcm_left}, 32'h0000_AAAA);
        chk("R10 repeat right", {16'h0, pcm_right}, 32'h0000_BBBB);
        bus_idle(8);
        chk("R8 masked irq stays low", {31'b0, irq}, 32'h0);
        bus_write(5'h10, 32'h2);
        chk("R8 irq with underrun unmasked", {31'b0, irq}, 32'h1);
        bus_read(5'h18, r); chk("R7 mask readback set", r, 32'h2);
        bus_write(5'h0C, 32'h2);
        chk("R6 ack clears underrun irq", {31'b0, irq}, 32'h0);
        bus_read(5'h08, r); chk("R6 status after ack", r, 32'h0);
        wait_strobe(600, seen);
        bus_idle(8);
        chk("R5 underrun raises irq", {31'b0, irq}, 32'h1);
        bus_write(5'h14, 32'h2);
        chk("R8 irq off after mask clear", {31'b0, irq}, 32'h0);
        bus_read(5'h18, r); chk("R7 mask readback cleared", r, 32'h0);
        bus_read(5'h08, r); chk("R5 underrun status bit", r, 32'h2);
    endtask

    task automatic t_busy_drop();
        bit seen;
        logic [31:0] r;
        wait_strobe(600, seen);
        bus_idle(8);
        bus_read(5'h08, r);
        bus_write(5'h04, 32'h2222_1111);
        bus_write(5'h04, 32'h4444_3333);
        wait_strobe(600, seen);
        chk("R12 first pair kept", {pcm_right, pcm_left}, 32'h2222_1111);
        bus_idle(8);
        bus_read(5'h08, r); chk("R5 no underrun when fed", r & 32'h2, 32'h0);
    endtask

    task automatic t_disable_again();
        bit seen;
        bus_write(5'h00, 32'h0);
        chk("R3 dma_req off on disable", {31'b0, dma_req}, 32'h0);
        bus_idle(4);
        wait_strobe(600, seen);
        chk("R3 strobes stop on disable", {31'b0, seen}, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge dac_clk); dac_rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_disabled();
        t_enable_ready();
        t_transfer();
        t_period();
        t_underrun();
        t_busy_drop();
        t_disable_again();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule